// File: doc/BRIEF.md
# Memory request slot tracker

This block keeps a small table of the memory requests that an in-order pipeline has outstanding. A request brings a thread id, a sequence number and an address. When it is granted, it takes the lowest-numbered free slot. The grant or denial is combinational in the request cycle, and the slot is occupied from the next clock edge. Data requests are held off while any occupied slot carries the same address. Instruction fetches skip that check, but their address still blocks later data requests.

The pipeline marks a slot as in flight once its memory access has been issued. It releases a slot once the access is finished with. A squash names a thread and a sequence number, and it cancels every younger request of that thread. A cancelled entry with no access in flight is vacated at once. A cancelled entry whose access is in flight stays put until its completion arrives. That completion is flagged as dropped, so no data is returned, and the slot is vacated.

Top module: `mem_slot_tracker`

## Requirements
- R1: A request with `req_addr_ok` low is denied (`req_deny`=1, `req_grant`=0) in the same cycle, whatever the table holds.
- R2: A data request (`req_fetch`=0) is denied while any occupied slot holds the same address. Otherwise it is granted, and `req_slot` gives the lowest-numbered free slot.
- R3: A fetch request (`req_fetch`=1) is granted even when an occupied slot holds its address. Its own address then blocks later data requests to that address.
- R4: A pulse on `rel_vld` vacates slot `rel_slot` at the next edge, so its address no longer blocks requests. Releasing a slot that is not occupied is an error.
- R5: A squash (`sq_vld`, `sq_tid`, `sq_seq`) cancels each occupied entry of thread `sq_tid` whose sequence number is strictly greater than `sq_seq`. Both numbers are compared as 16-bit unsigned values. Entries with an equal or smaller number, and entries of other threads, are left alone.
- R6: `issue_vld` marks slot `issue_slot` as having its access in flight. A cancelled entry with no access in flight is vacated at the squash edge. A cancelled entry with an access in flight stays occupied, and its address keeps blocking, until its completion arrives.
- R7: A completion (`done_vld`, `done_slot`) for a cancelled entry gives `done_drop`=1 and `done_keep`=0, and the slot is vacated. For an entry that was not cancelled it gives `done_keep`=1 and `done_drop`=0, and the slot stays occupied until it is released.
- R8: With all four slots occupied, every request is denied in the same cycle.
- R9: A request that is younger than a squash arriving in the same cycle for the same thread is denied. A request from another thread is still granted, and so is one whose number is not greater than the squash number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Allocation request strobe |
| req_fetch | input | 1 | Request comes from the instruction-fetch side |
| req_addr_ok | input | 1 | Request address is valid |
| req_addr | input | 32 | Request address |
| req_tid | input | 2 | Request thread id |
| req_seq | input | 16 | Request sequence number |
| req_grant | output | 1 | Request accepted this cycle |
| req_deny | output | 1 | Request refused this cycle |
| req_slot | output | 2 | Slot assigned on grant |
| issue_vld | input | 1 | Memory access issued for a slot |
| issue_slot | input | 2 | Slot whose access was issued |
| rel_vld | input | 1 | Release strobe |
| rel_slot | input | 2 | Slot to release |
| sq_vld | input | 1 | Squash strobe |
| sq_tid | input | 2 | Thread to squash |
| sq_seq | input | 16 | Entries younger than this are squashed |
| done_vld | input | 1 | Memory completion strobe |
| done_slot | input | 2 | Slot whose access completed |
| done_keep | output | 1 | Completion delivers data |
| done_drop | output | 1 | Completion is discarded |

## Verification
The address check is tried in three ways: a repeated data address, a new address, and a data request that lands on an address a fetch holds. Together these separate the conflict test from the fetch exemption. For squashes, the bench places entries with an equal sequence number, a greater one, and an entry from another thread side by side. This exposes a wrong comparison operator, and 0x8000 against 1 exposes a signed comparison. Squashed entries with and without an access in flight are followed up by probing their addresses and by completions. This separates immediate release from deferred release, and dropped completions from kept ones.

// File: rtl/mem_slot_tracker.sv
module mem_slot_tracker #(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int TW    = 2,
  localparam int SIW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_vld,
  input  logic           req_fetch,
  input  logic           req_addr_ok,
  input  logic [AW-1:0]  req_addr,
  input  logic [TW-1:0]  req_tid,
  input  logic [SW-1:0]  req_seq,
  output logic           req_grant,
  output logic           req_deny,
  output logic [SIW-1:0] req_slot,
  input  logic           issue_vld,
  input  logic [SIW-1:0] issue_slot,
  input  logic           rel_vld,
  input  logic [SIW-1:0] rel_slot,
  input  logic           sq_vld,
  input  logic [TW-1:0]  sq_tid,
  input  logic [SW-1:0]  sq_seq,
  input  logic           done_vld,
  input  logic [SIW-1:0] done_slot,
  output logic           done_keep,
  output logic           done_drop
);

  logic [NSLOT-1:0] vld, pnd, sqd, sq_hit;
  logic [AW-1:0]    adr [NSLOT];
  logic [TW-1:0]    tid [NSLOT];
  logic [SW-1:0]    seq [NSLOT];

  logic           hit, free_found, sq_blk, done_sq;
  logic [SIW-1:0] free_idx;

  always_comb begin
    hit        = 1'b0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (vld[i] && adr[i] == req_addr) hit = 1'b1;
      if (!vld[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = SIW'(i);
      end
    end
  end

  assign sq_blk    = sq_vld && req_tid == sq_tid && req_seq > sq_seq;
  assign req_grant = req_vld && req_addr_ok && free_found && (req_fetch || !hit) && !sq_blk;
  assign req_deny  = req_vld && !req_grant;
  assign req_slot  = free_idx;

  assign done_sq   = sqd[done_slot] || sq_hit[done_slot];
  assign done_drop = done_vld && done_sq;
  assign done_keep = done_vld && !done_sq;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic take, clr;
    assign sq_hit[g] = sq_vld && vld[g] && tid[g] == sq_tid && seq[g] > sq_seq;
    assign take = req_grant && free_idx == SIW'(g);
    assign clr  = (rel_vld && rel_slot == SIW'(g))
               || (done_vld && done_slot == SIW'(g) && done_sq)
               || (sq_hit[g] && !pnd[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        pnd[g] <= 1'b0;
        sqd[g] <= 1'b0;
        adr[g] <= '0;
        tid[g] <= '0;
        seq[g] <= '0;
      end else begin
        if (take) begin
          vld[g] <= 1'b1;
          adr[g] <= req_addr;
          tid[g] <= req_tid;
          seq[g] <= req_seq;
        end
        if (issue_vld && issue_slot == SIW'(g)) pnd[g] <= 1'b1;
        if (done_vld && done_slot == SIW'(g)) pnd[g] <= 1'b0;
        if (sq_hit[g]) sqd[g] <= 1'b1;
        if (clr) begin
          vld[g] <= 1'b0;
          pnd[g] <= 1'b0;
          sqd[g] <= 1'b0;
        end
      end
    end
  end

  assert_no_grant_wo_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> req_addr_ok);
  assert_grant_occupies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |=> vld[$past(req_slot)]);
  assert_release_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld |-> vld[rel_slot]);
  assert_squashed_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sqd & ~pnd) == '0);
  assert_done_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> pnd[done_slot]);
  assert_done_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_keep && done_drop));
  assert_full_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld) |-> !req_grant);
  assert_sq_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && req_vld && req_tid == sq_tid && req_seq > sq_seq) |-> req_deny);

endmodule

// File: tb/mem_slot_tracker_bench.sv
module mem_slot_tracker_bench;
  logic clk = 0, rst_n = 0;
  logic req_vld = 0, req_fetch = 0, req_addr_ok = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_tid = 0;
  logic [15:0] req_seq = 0;
  logic req_grant, req_deny;
  logic [1:0] req_slot;
  logic issue_vld = 0; logic [1:0] issue_slot = 0;
  logic rel_vld = 0;   logic [1:0] rel_slot = 0;
  logic sq_vld = 0;    logic [1:0] sq_tid = 0; logic [15:0] sq_seq = 0;
  logic done_vld = 0;  logic [1:0] done_slot = 0;
  logic done_keep, done_drop;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mem_slot_tracker u_mem_slot_tracker (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_vld = 0; issue_vld = 0; rel_vld = 0; sq_vld = 0; done_vld = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic set_req(bit f, bit ok, logic [31:0] a, logic [1:0] t, logic [15:0] s);
    req_vld = 1; req_fetch = f; req_addr_ok = ok; req_addr = a; req_tid = t; req_seq = s;
  endtask

  task automatic alloc(string tag, bit f, bit ok, logic [31:0] a, logic [1:0] t,
                       logic [15:0] s, bit eg, logic [1:0] es);
    set_req(f, ok, a, t, s);
    #2;
    chk({tag, " grant"}, req_grant, eg);
    chk({tag, " deny"}, req_deny, !eg);
    if (eg) chk({tag, " slot"}, req_slot, es);
    @(negedge clk); idle();
  endtask

  task automatic squash(logic [1:0] t, logic [15:0] s);
    sq_vld = 1; sq_tid = t; sq_seq = s;
    @(negedge clk); idle();
  endtask

  task automatic issue(logic [1:0] sl);
    issue_vld = 1; issue_slot = sl;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    chk("R2 reset no grant", req_grant, 0);
    chk("R7 reset no done", {done_keep, done_drop}, 0);
    alloc("R2 first", 0, 1, 32'h40, 0, 1, 1, 0);
  endtask

  task automatic t_no_addr();
    do_reset();
    alloc("R1 invalid addr", 0, 0, 32'h80, 0, 1, 0, 0);
    alloc("R1 then valid", 0, 1, 32'h80, 0, 1, 1, 0);
  endtask

  task automatic t_conflict();
    do_reset();
    alloc("R2 a", 0, 1, 32'hA0, 0, 1, 1, 0);
    alloc("R2 repeat a", 0, 1, 32'hA0, 1, 2, 0, 0);
    alloc("R2 b", 0, 1, 32'hB0, 0, 3, 1, 1);
    alloc("R3 fetch a", 1, 1, 32'hA0, 0, 4, 1, 2);
    rel_vld = 1; rel_slot = 0; @(negedge clk); idle();
    alloc("R3 fetch blocks data", 0, 1, 32'hA0, 0, 5, 0, 0);
    rel_vld = 1; rel_slot = 2; @(negedge clk); idle();
    alloc("R4 released a", 0, 1, 32'hA0, 0, 6, 1, 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 4; i++)
      alloc("R8 fill", 0, 1, 32'h100 + 32'(i), 0, 16'(i), 1, 2'(i));
    alloc("R8 full", 1, 1, 32'h200, 0, 9, 0, 0);
    rel_vld = 1; rel_slot = 2; @(negedge clk); idle();
    alloc("R4 reuse slot", 0, 1, 32'h200, 0, 9, 1, 2);
  endtask

  task automatic t_squash();
    do_reset();
    alloc("R5 s5", 0, 1, 32'h300, 1, 5, 1, 0);
    alloc("R5 s6", 0, 1, 32'h304, 1, 6, 1, 1);
    alloc("R5 s7", 0, 1, 32'h308, 1, 7, 1, 2);
    alloc("R5 other", 0, 1, 32'h30C, 0, 9, 1, 3);
    squash(1, 5);
    alloc("R5 younger freed", 0, 1, 32'h304, 2, 1, 1, 1);
    alloc("R5 other thread kept", 0, 1, 32'h30C, 2, 1, 0, 0);
    alloc("R5 equal seq kept", 0, 1, 32'h300, 2, 1, 0, 0);
    alloc("R6 second freed", 0, 1, 32'h308, 2, 1, 1, 2);
  endtask

  task automatic t_unsigned();
    do_reset();
    alloc("R5 big seq", 0, 1, 32'h500, 0, 16'h8000, 1, 0);
    squash(0, 1);
    alloc("R5 unsigned compare", 0, 1, 32'h500, 0, 2, 1, 0);
  endtask

  task automatic t_deferred();
    do_reset();
    alloc("R6 s3", 0, 1, 32'h600, 0, 3, 1, 0);
    issue(0);
    alloc("R6 s2", 0, 1, 32'h700, 0, 2, 1, 1);
    squash(0, 2);
    alloc("R6 in flight blocks", 0, 1, 32'h600, 1, 1, 0, 0);
    alloc("R6 slot held", 0, 1, 32'h800, 1, 1, 1, 2);
    done_vld = 1; done_slot = 0; #2;
    chk("R7 drop", done_drop, 1);
    chk("R7 no keep", done_keep, 0);
    @(negedge clk); idle();
    alloc("R7 dropped freed", 0, 1, 32'h600, 1, 2, 1, 0);
    issue(1);
    done_vld = 1; done_slot = 1; #2;
    chk("R7 keep", done_keep, 1);
    chk("R7 keep no drop", done_drop, 0);
    @(negedge clk); idle();
    alloc("R7 kept stays", 0, 1, 32'h700, 1, 3, 0, 0);
  endtask

  task automatic t_priority();
    do_reset();
    sq_vld = 1; sq_tid = 1; sq_seq = 10;
    set_req(0, 1, 32'h900, 1, 11); #2;
    chk("R9 younger denied", req_deny, 1);
    req_seq = 10; #1;
    chk("R9 equal granted", req_grant, 1);
    req_tid = 0; req_seq = 50; #1;
    chk("R9 other thread granted", req_grant, 1);
    @(negedge clk); idle();
  endtask

  initial begin
    t_reset();
    t_no_addr();
    t_conflict();
    t_full();
    t_squash();
    t_unsigned();
    t_deferred();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule